// File: doc/BRIEF.md
# Stereo PDM Microphone Receiver

This block drives the bit clock for two digital microphones that share one data wire. Each microphone answers in its own half of the clock period. The block samples the wire once per clock phase, at the last system cycle before the edge that closes that phase, so the data has settled. It sorts the two samples of each period into a left and a right one-bit density stream. A run-time select decides which clock level belongs to the left microphone.

Each stream goes through a third-order CIC decimator with a fixed ratio of 64 microphone periods per output. This gives a microphone clock of 64 times the audio rate. The decimator result is offset and scaled into a signed sample, and the top of the range is clipped rather than allowed to wrap. Both channels share one valid strobe.

When the enable input is low, the microphone clock stays low and all filter state is cleared. The first outputs after enabling are held back until the filter pipeline has filled.

Top module: `pdm_stereo_rx`

## Requirements
- R1: While enabled, the microphone clock toggles every HALF_DIV system cycles. After n rising system edges with the enable high, it equals floor(n / HALF_DIV) mod 2. It starts low.
- R2: While the enable is low, the microphone clock is low from the next system edge on.
- R3: With the polarity select at 1, the bit sampled while the microphone clock is high feeds the left channel, and the bit sampled while it is low feeds the right channel.
- R4: With the polarity select at 0, the bit sampled while the clock is high feeds the right channel, and the bit sampled while it is low feeds the left channel.
- R5: A channel whose stream is all ones settles to 32767 (the largest code, reached by clipping). A channel whose stream is all zeros settles to -32768, with the default 16-bit output.
- R6: A channel whose stream alternates between 1 and 0 on every sample it receives settles to code 0.
- R7: The valid output is a one-cycle pulse that marks both channel outputs together. Consecutive pulses are exactly 64 microphone periods apart, which is 128*HALF_DIV system cycles.
- R8: After the enable rises, no valid pulse appears within the first 3 output periods. The first pulse comes no later than 5 output periods after the enable rises.
- R9: No valid pulse is produced while the enable is low, and disabling clears the filter state, so R8 applies again on the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Interface enable; low stops the clock and clears state |
| pol_hi_left | input | 1 | 1: clock-high data is left; 0: clock-high data is right |
| pdm_in | input | 1 | Shared microphone data line |
| mic_clk | output | 1 | Microphone bit clock |
| out_valid | output | 1 | One-cycle strobe for both sample outputs |
| left_pcm | output | OUT_W | Signed left sample |
| right_pcm | output | OUT_W | Signed right sample |

## Verification
The microphone clock is due one edge after any change: the bench's counter model predicts its level from the number of enabled edges and compares it on every falling system edge. Valid strobes are timed against the same edge count. Each strobe after the first in an enable session must land exactly 128*HALF_DIV cycles after the one before. The first strobe must fall inside the window of 3 to 5 output periods. Sample values settle only after the filter has passed the new pattern through. For that reason the bench ignores the first three strobes after any change of pattern or polarity and checks the codes on the strobes that follow.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;
  localparam int DEC_RATIO    = 64;
  localparam int DEC_BITS     = 6;
  localparam int CIC_ORDER    = 3;
  localparam int GAIN_BITS    = CIC_ORDER * DEC_BITS;
  localparam int ACC_W        = GAIN_BITS + 1;
  localparam int FILL_OUTPUTS = 3;
endpackage

// File: rtl/pdm_clk_gen.sv
module pdm_clk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mic_clk,
  output logic smp_stb,
  output logic smp_high
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          level;
  logic          phase_end;

  assign phase_end = (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (phase_end) begin
      cnt   <= '0;
      level <= ~level;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign mic_clk  = level;
  assign smp_stb  = en && phase_end;
  assign smp_high = level;
endmodule

// File: rtl/pdm_cic.sv
module pdm_cic
  import pdm_rx_pkg::*;
(
  input  logic             clk,
  input  logic             clr,
  input  logic             in_stb,
  input  logic             bit_in,
  input  logic             dec_stb,
  output logic [ACC_W-1:0] acc_out
);
  logic [ACC_W-1:0] integ [CIC_ORDER];
  logic [ACC_W-1:0] dly   [CIC_ORDER];
  logic [ACC_W-1:0] stage [CIC_ORDER+1];

  always_comb begin
    stage[0] = integ[CIC_ORDER-1];
    for (int k = 0; k < CIC_ORDER; k++) begin
      stage[k+1] = stage[k] - dly[k];
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int k = 0; k < CIC_ORDER; k++) begin
        integ[k] <= '0;
        dly[k]   <= '0;
      end
      acc_out <= '0;
    end else begin
      if (in_stb) begin
        integ[0] <= integ[0] + ACC_W'(bit_in);
        for (int k = 1; k < CIC_ORDER; k++) begin
          integ[k] <= integ[k] + integ[k-1];
        end
      end
      if (dec_stb) begin
        for (int k = 0; k < CIC_ORDER; k++) begin
          dly[k] <= stage[k];
        end
        acc_out <= stage[CIC_ORDER];
      end
    end
  end

  assert_dec_on_sample_R7: assert property (@(posedge clk) disable iff (clr)
    dec_stb |-> in_stb);
endmodule

// File: rtl/pdm_stereo_rx.sv
module pdm_stereo_rx
  import pdm_rx_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int OUT_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    pol_hi_left,
  input  logic                    pdm_in,
  output logic                    mic_clk,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] left_pcm,
  output logic signed [OUT_W-1:0] right_pcm
);
  localparam int SHIFT = GAIN_BITS - OUT_W;
  localparam logic signed [ACC_W:0] MID  = (ACC_W+1)'(1) << (GAIN_BITS - 1);
  localparam logic signed [ACC_W:0] TOPV = (ACC_W+1)'((1 << (OUT_W - 1)) - 1);

  logic                smp_stb, smp_high;
  logic                hi_bit;
  logic                pair_v;
  logic [1:0]          ch_bit;
  logic [DEC_BITS-1:0] dcnt;
  logic                dec_stb;
  logic [1:0]          fill;
  logic                take;
  logic                clr;
  logic [ACC_W-1:0]    acc [2];

  function automatic logic signed [OUT_W-1:0] to_pcm(input logic [ACC_W-1:0] a);
    logic signed [ACC_W:0] c;
    logic signed [ACC_W:0] s;
    c = $signed({1'b0, a}) - MID;
    s = c >>> SHIFT;
    if (s > TOPV) return TOPV[OUT_W-1:0];
    return s[OUT_W-1:0];
  endfunction

  assign clr = rst || !en;

  pdm_clk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .en(en),
    .mic_clk(mic_clk), .smp_stb(smp_stb), .smp_high(smp_high)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      hi_bit <= 1'b0;
      pair_v <= 1'b0;
      ch_bit <= '0;
    end else begin
      pair_v <= 1'b0;
      if (smp_stb && smp_high) hi_bit <= pdm_in;
      if (smp_stb && !smp_high) begin
        pair_v    <= 1'b1;
        ch_bit[0] <= pol_hi_left ? hi_bit : pdm_in;
        ch_bit[1] <= pol_hi_left ? pdm_in : hi_bit;
      end
    end
  end

  assign dec_stb = pair_v && (dcnt == '1);

  always_ff @(posedge clk) begin
    if (clr) begin
      dcnt <= '0;
      fill <= '0;
      take <= 1'b0;
    end else begin
      if (pair_v) dcnt <= dcnt + 1'b1;
      if (dec_stb && fill != 2'(FILL_OUTPUTS)) fill <= fill + 1'b1;
      take <= dec_stb && (fill == 2'(FILL_OUTPUTS));
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_ch
    pdm_cic u_cic (
      .clk(clk), .clr(clr), .in_stb(pair_v), .bit_in(ch_bit[g]),
      .dec_stb(dec_stb), .acc_out(acc[g])
    );
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      out_valid <= 1'b0;
      left_pcm  <= '0;
      right_pcm <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        left_pcm  <= to_pcm(acc[0]);
        right_pcm <= to_pcm(acc[1]);
      end
    end
  end

  assert_clk_low_off_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mic_clk);
  assert_quiet_off_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !out_valid);
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  assert_pair_after_low_R1: assert property (@(posedge clk) disable iff (rst)
    pair_v |-> mic_clk);
endmodule

// File: tb/pdm_stereo_rx_bench.sv
module pdm_stereo_rx_bench;
  localparam int HALF = 2;
  localparam int P    = 128 * HALF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic pol = 1'b0;
  logic pdm_in;
  logic mic_clk, out_valid;
  logic signed [15:0] left_pcm, right_pcm;

  int checks = 0, fails = 0;
  int hi_kind = 0, lo_kind = 0;
  int settle = 3;
  int n = 0, last_v = -1;
  logic tgl = 1'b0;

  always #2.5 clk = ~clk;

  pdm_stereo_rx #(.HALF_DIV(HALF), .OUT_W(16)) u_pdm_stereo_rx (
    .clk(clk), .rst(rst), .en(en), .pol_hi_left(pol), .pdm_in(pdm_in),
    .mic_clk(mic_clk), .out_valid(out_valid),
    .left_pcm(left_pcm), .right_pcm(right_pcm)
  );

  function automatic logic bit_of(int k, logic t);
    return (k == 2) ? t : logic'(k[0]);
  endfunction

  function automatic int code_of(int k);
    return (k == 2) ? 0 : ((k == 1) ? 32767 : -32768);
  endfunction

  always @(posedge mic_clk) tgl <= ~tgl;
  assign pdm_in = mic_clk ? bit_of(hi_kind, tgl) : bit_of(lo_kind, tgl);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle model: evaluated on every falling edge, using inputs as seen at the last rising edge.
  always @(negedge clk) begin
    if (rst || !en) begin
      n = 0;
      last_v = -1;
      check("R2 mic_clk low while disabled", int'(mic_clk), 0);
      if (!rst) check("R9 no valid while disabled", int'(out_valid), 0);
    end else begin
      n++;
      check("R1 mic_clk level", int'(mic_clk), (n / HALF) % 2);
      if (out_valid) begin
        if (last_v < 0) begin
          check("R8 first valid not before 3 periods", int'(n >= 3 * P), 1);
          check("R8 first valid by 5 periods", int'(n <= 5 * P), 1);
        end else begin
          check("R7 valid spacing", n - last_v, P);
        end
        last_v = n;
        if (settle > 0) settle--;
        else begin
          check(pol ? "R3 left value" : "R4 left value", int'(left_pcm),
                code_of(pol ? hi_kind : lo_kind));
          check(pol ? "R3 right value" : "R4 right value", int'(right_pcm),
                code_of(pol ? lo_kind : hi_kind));
          if (hi_kind != 2 && lo_kind != 2)
            check("R5 full-scale pair", int'(left_pcm) + int'(right_pcm),
                  (hi_kind == lo_kind) ? 2 * code_of(hi_kind) : -1);
          else
            check("R6 alternating channel zero", int'((pol ? hi_kind : lo_kind) == 2 ? left_pcm : right_pcm), 0);
        end
      end
    end
  end

  task automatic wait_valids(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      while (!out_valid) @(negedge clk);
    end
  endtask

  task automatic apply(logic p, int h, int l);
    @(negedge clk); #1;
    pol = p; hi_kind = h; lo_kind = l; settle = 3;
    wait_valids(5);
  endtask

  task automatic run_all();
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R2 reset mic_clk", int'(mic_clk), 0);
    check("R9 reset valid", int'(out_valid), 0);
    check("R5 reset left code", int'(left_pcm), 0);
    #1 en = 1'b1; pol = 1'b1; hi_kind = 1; lo_kind = 0; settle = 3;
    wait_valids(5);
    apply(1'b1, 0, 1);
    apply(1'b0, 1, 0);
    apply(1'b0, 0, 1);
    apply(1'b1, 1, 1);
    apply(1'b0, 0, 0);
    apply(1'b1, 2, 1);
    apply(1'b0, 0, 2);
    apply(1'b1, 2, 0);
    @(negedge clk); #1 en = 1'b0; hi_kind = 1; lo_kind = 1;
    repeat (3 * P) @(negedge clk);
    #1 en = 1'b1; pol = 1'b0; hi_kind = 1; lo_kind = 0; settle = 3;
    wait_valids(5);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule